// File: doc/BRIEF.md
# Playback Status Pin Generator

This block turns the playback state of a voice player into three programmable status pins. From a sample-rate tick, a busy level and a one-cycle end-of-group event, it builds four internal status signals: two complementary flash signals for indicator lamps, a busy level, and a positive pulse marking the end of a group's playback. A 2-bit per-group pin map chooses which of these signals appears on each of the three pins. A per-group enable says whether the end pulse is produced at all.

The flash period and the end-pulse width are counted in sample ticks, so both scale with the sample rate. The busy level is counted in system clocks and has a fixed one-clock delay. The pin map and the end-pulse enable are taken when busy rises and held for the whole group. As a result, the end pulse of a group uses that group's options, even if the controller has already presented the next group's options.

Top module: `status_pin_gen`

## Requirements
- R1: While reset is asserted, and after reset while idle with the reset pin map (code 0), all three pins are low.
- R2: The internal busy signal follows `busy_i` exactly one clock later, on both the rising and the falling change.
- R3: While busy, the two flash signals are always complements of each other. While idle, both flash signals are low.
- R4: When busy rises, the flash phase restarts with flash A high. After that, the flash signals swap every `LED_HALF_TICKS` sample ticks and do not change between ticks.
- R5: If the latched end-pulse enable is 1, a `grp_end_i` event raises the end pulse on the next clock. The pulse stays high until `STOP_TICKS` sample ticks have been counted, then falls.
- R6: If the latched end-pulse enable is 0, a `grp_end_i` event produces no end pulse.
- R7: Pin map codes (pins listed out1/out2/out3): code 0 gives flash B / flash A / busy; code 1 gives end pulse / flash A / flash B; code 2 gives flash A / busy / end pulse; code 3 gives flash A / busy / inverted busy.
- R8: `grp_map_i` and `grp_stop_en_i` are sampled only in the cycle where busy rises. Changes at any other time have no effect on the pins.
- R9: A `grp_end_i` event that arrives while an end pulse is running restarts its count, so the pulse lasts a full `STOP_TICKS` ticks from the last event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick_i | input | 1 | One-cycle pulse, once per audio sample |
| busy_i | input | 1 | High while a group is playing |
| grp_end_i | input | 1 | One-cycle event marking the end of a group |
| grp_map_i | input | 2 | Pin map code of the group being started |
| grp_stop_en_i | input | 1 | End-pulse enable of the group being started |
| out1_o | output | 1 | Status pin 1 |
| out2_o | output | 1 | Status pin 2 |
| out3_o | output | 1 | Status pin 3 |

## Verification
The bench builds the block with `LED_HALF_TICKS` = 3 and `STOP_TICKS` = 4. With these values, several flash swaps and the complete end-pulse window, including its last tick, fit into a few dozen cycles. This short window allows a full sweep of all four pin maps against both end-pulse enables. In every combination the bench alters the map and enable inputs in the middle of playback, and it also re-fires the end event during a running pulse.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;

    typedef enum logic [1:0] {
        MAP_FB_FA_BZ = 2'd0,
        MAP_EP_FA_FB = 2'd1,
        MAP_FA_BZ_EP = 2'd2,
        MAP_FA_BZ_NB = 2'd3
    } pin_map_e;

    typedef struct packed {
        logic flash_a;
        logic flash_b;
        logic endp;
        logic busy;
    } stat_sig_t;

endpackage

// File: rtl/status_flasher.sv
module status_flasher #(
    parameter int LED_HALF_TICKS = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic busy_i,
    input  logic busy_q_i,
    output logic flash_a_o,
    output logic flash_b_o
);
    localparam int CW = (LED_HALF_TICKS > 1) ? $clog2(LED_HALF_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(LED_HALF_TICKS - 1);

    typedef struct packed {
        logic          phase;
        logic [CW-1:0] cnt;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_i && !busy_q_i) begin
            st_d.phase = 1'b1;
            st_d.cnt   = '0;
        end else if (!busy_q_i) begin
            st_d.phase = 1'b0;
            st_d.cnt   = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flash_a_o = busy_q_i & st_q.phase;
    assign flash_b_o = busy_q_i & ~st_q.phase;

endmodule

// File: rtl/status_endpulse.sv
module status_endpulse #(
    parameter int STOP_TICKS = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic end_i,
    input  logic en_i,
    output logic pulse_o
);
    localparam int CW = $clog2(STOP_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(STOP_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (end_i && en_i) begin
            cnt_d = LOAD;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
    import status_pin_pkg::*;
(
    input  pin_map_e  map_i,
    input  stat_sig_t sig_i,
    output logic      out1_o,
    output logic      out2_o,
    output logic      out3_o
);
    always_comb begin
        unique case (map_i)
            MAP_FB_FA_BZ: begin
                out1_o = sig_i.flash_b;
                out2_o = sig_i.flash_a;
                out3_o = sig_i.busy;
            end
            MAP_EP_FA_FB: begin
                out1_o = sig_i.endp;
                out2_o = sig_i.flash_a;
                out3_o = sig_i.flash_b;
            end
            MAP_FA_BZ_EP: begin
                out1_o = sig_i.flash_a;
                out2_o = sig_i.busy;
                out3_o = sig_i.endp;
            end
            default: begin
                out1_o = sig_i.flash_a;
                out2_o = sig_i.busy;
                out3_o = ~sig_i.busy;
            end
        endcase
    end

endmodule

// File: rtl/status_pin_gen.sv
module status_pin_gen
    import status_pin_pkg::*;
#(
    parameter int LED_HALF_TICKS = 1500,
    parameter int STOP_TICKS     = 384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_tick_i,
    input  logic       busy_i,
    input  logic       grp_end_i,
    input  logic [1:0] grp_map_i,
    input  logic       grp_stop_en_i,
    output logic       out1_o,
    output logic       out2_o,
    output logic       out3_o
);
    typedef struct packed {
        logic     busy;
        pin_map_e map;
        logic     stop_en;
    } top_state_t;

    top_state_t st_d, st_q;
    stat_sig_t  sig;
    logic       busy_w;
    logic       stop_en_w;
    logic [1:0] map_w;

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy_i;
        if (busy_i && !st_q.busy) begin
            st_d.map     = pin_map_e'(grp_map_i);
            st_d.stop_en = grp_stop_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, map: MAP_FB_FA_BZ, stop_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_w    = st_q.busy;
    assign stop_en_w = st_q.stop_en;
    assign map_w     = st_q.map;

    status_flasher #(.LED_HALF_TICKS(LED_HALF_TICKS)) u_flash (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (smp_tick_i),
        .busy_i   (busy_i),
        .busy_q_i (st_q.busy),
        .flash_a_o(sig.flash_a),
        .flash_b_o(sig.flash_b)
    );

    status_endpulse #(.STOP_TICKS(STOP_TICKS)) u_endp (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (smp_tick_i),
        .end_i  (grp_end_i),
        .en_i   (st_q.stop_en),
        .pulse_o(sig.endp)
    );

    assign sig.busy = st_q.busy;

    status_pin_mux u_mux (
        .map_i (st_q.map),
        .sig_i (sig),
        .out1_o(out1_o),
        .out2_o(out2_o),
        .out3_o(out3_o)
    );

endmodule

// File: rtl/status_pin_gen_chk.sv
module status_pin_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_tick_i,
    input logic       busy_i,
    input logic       grp_end_i,
    input logic       busy_q,
    input logic       stop_en_q,
    input logic [1:0] map_q,
    input logic       flash_a,
    input logic       flash_b,
    input logic       endp,
    input logic       out2,
    input logic       out3
);
    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> busy_q);
    p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> !busy_q);
    p_flash_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (flash_a && !flash_b));
    p_flash_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && busy_q && !smp_tick_i) |=> $stable(flash_a));
    p_flash_compl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (flash_a != flash_b));
    p_stop_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end_i && stop_en_q) |=> endp);
    p_stop_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_end_i && !stop_en_q && !endp) |=> !endp);
    p_map_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && busy_q) |=> $stable(map_q));
    p_inv_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (map_q == 2'd3) |-> (out3 != out2));
endmodule

bind status_pin_gen status_pin_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_tick_i(smp_tick_i),
    .busy_i    (busy_i),
    .grp_end_i (grp_end_i),
    .busy_q    (busy_w),
    .stop_en_q (stop_en_w),
    .map_q     (map_w),
    .flash_a   (sig.flash_a),
    .flash_b   (sig.flash_b),
    .endp      (sig.endp),
    .out2      (out2_o),
    .out3      (out3_o)
);

// File: tb/status_pin_gen_tb.sv
module status_pin_gen_tb;
    localparam int HALF = 3;
    localparam int STOPW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       busy = 1'b0;
    logic       gend = 1'b0;
    logic [1:0] gmap = 2'd0;
    logic       gen = 1'b0;
    logic       o1, o2, o3;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    status_pin_gen #(.LED_HALF_TICKS(HALF), .STOP_TICKS(STOPW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_tick_i   (tick),
        .busy_i       (busy),
        .grp_end_i    (gend),
        .grp_map_i    (gmap),
        .grp_stop_en_i(gen),
        .out1_o       (o1),
        .out2_o       (o2),
        .out3_o       (o3)
    );

    // expected {out1,out2,out3} from the R7 map table
    function automatic logic [2:0] exp_pins(int code, bit fa, bit fb, bit bz, bit ep);
        case (code)
            0:       return {fb, fa, bz};
            1:       return {ep, fa, fb};
            2:       return {fa, bz, ep};
            default: return {fa, bz, ~bz};
        endcase
    endfunction

    task automatic chk(string req, logic [2:0] exp);
        n_chk++;
        if ({o1, o2, o3} !== exp) begin
            n_fail++;
            $display("FAIL %s: pins actual %b expected %b", req, {o1, o2, o3}, exp);
        end
    endtask

    task automatic step(bit t, bit b, bit e);
        @(negedge clk);
        tick = t;
        busy = b;
        gend = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        chk("R1 in reset", 3'b000);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(0, 0, 0);
        chk("R1 idle after reset", 3'b000);

        for (int s = 0; s < 4; s++) begin
            for (int en = 0; en < 2; en++) begin
                gmap = 2'(s);
                gen  = en[0];
                step(0, 1, 0);
                chk("R2 R4 busy rise, flash A first", exp_pins(s, 1, 0, 1, 0));
                gmap = 2'(~s);
                gen  = ~en[0];
                for (int k = 1; k <= 4 * HALF + 2; k++) begin
                    bit fa;
                    fa = ((k / HALF) % 2) == 0;
                    step(1, 1, 0);
                    chk("R3 R4 R8 flash after tick", exp_pins(s, fa, !fa, 1, 0));
                    step(0, 1, 0);
                    chk("R4 flash holds between ticks", exp_pins(s, fa, !fa, 1, 0));
                end
                step(0, 0, 1);
                chk("R2 R5 R6 end event", exp_pins(s, 0, 0, 0, en[0]));
                for (int m = 1; m <= STOPW + 2; m++) begin
                    step(1, 0, 0);
                    chk("R5 R6 end pulse width", exp_pins(s, 0, 0, 0, en[0] && (m < STOPW)));
                    step(0, 0, 0);
                end
                step(0, 0, 1);
                step(1, 0, 0);
                step(1, 0, 0);
                step(0, 0, 1);
                chk("R9 retrigger", exp_pins(s, 0, 0, 0, en[0]));
                for (int m = 1; m <= STOPW + 1; m++) begin
                    step(1, 0, 0);
                    chk("R9 retrigger width", exp_pins(s, 0, 0, 0, en[0] && (m < STOPW)));
                end
                step(0, 0, 0);
                chk("R3 R8 idle pins", exp_pins(s, 0, 0, 0, 0));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule